// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block follows the low-power state of a mobile SDRAM from the clock-enable (CKE) pin and the command sampled on each rising clock edge. It keeps the CKE level from the previous edge and compares it with the current level. Using that pair, the decoded command and two flags from the bank logic (all banks idle, read or write burst in progress), it decides whether the memory enters, stays in or leaves power-down, self refresh, clock suspend or deep power-down.

Self-refresh exit includes a recovery window of `XSR_CYCLES` clock edges. During this window only inhibit and NOP commands are legal, and at least two true NOPs must be seen. Leaving deep power-down puts the device in an uninitialised state. It stays there until an external init-done strobe arrives while CKE is high.

A controller uses the accept flag to know when ordinary commands may be issued. A device model uses the sticky illegal flag to catch a sequence that is reserved or out of order.

Top module: `sdram_pwr_tracker`

## Requirements
- R1: After reset the state output is NORMAL (code 0), the accept output is 1 and the illegal output is 0. The stored previous CKE level is taken as high.
- R2: In NORMAL with banks idle and no access active, a CKE fall with inhibit (cmd code 0) or NOP (code 1) moves the block to POWER-DOWN (code 1). POWER-DOWN holds while CKE stays low, whatever the command. A CKE rise with inhibit or NOP returns the block to NORMAL.
- R3: In NORMAL with banks idle and no access active, a CKE fall with auto refresh (code 2) moves the block to SELF-REFRESH (code 2). SELF-REFRESH holds while CKE stays low, whatever the command.
- R4: The burst-terminate code (3) is accepted as an ordinary command while CKE stays high, and the state does not change. A CKE fall with code 3, banks idle and no access active moves the block to DEEP POWER-DOWN (code 5).
- R5: In NORMAL with an access active, a CKE fall with any command code moves the block to CLOCK-SUSPEND (code 4). The block holds there while CKE is low. A CKE rise returns it to NORMAL, and the accept output is 1 in the next cycle.
- R6: From SELF-REFRESH, a CKE rise with inhibit or NOP moves the block to RECOVERY (code 3). The block leaves RECOVERY for NORMAL on the first edge that meets three conditions: at least `XSR_CYCLES` edges have passed in RECOVERY, at least two NOPs were sampled in RECOVERY, and the command on that edge is inhibit or NOP with CKE high. RECOVERY therefore lasts at least `XSR_CYCLES`+1 cycles.
- R7: Inhibit commands during RECOVERY do not count toward the two-NOP minimum. Once the recovery count has expired, the block stays in RECOVERY until the second NOP has been sampled.
- R8: From DEEP POWER-DOWN, a CKE rise with inhibit or NOP moves the block to UNINIT (code 6). UNINIT stays until an edge with `init_done_i` high and CKE high, which moves the block to NORMAL.
- R9: The accept output is 1 only in NORMAL and is 0 in every other state, RECOVERY included.
- R10: The following events are illegal: a CKE fall in NORMAL with any command other than 0..3, or with neither idle nor access; a command other than inhibit/NOP on a POWER-DOWN, SELF-REFRESH or DEEP POWER-DOWN exit edge, in RECOVERY or in UNINIT; CKE low in RECOVERY. An illegal edge leaves the state unchanged and sets the illegal output, which stays 1 until reset. Codes 5..7 are treated like code 4 (other valid command).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock-enable level sampled at this edge |
| cmd_i | input | 3 | Decoded command: 0 inhibit, 1 NOP, 2 auto refresh, 3 burst terminate, 4..7 other valid |
| banks_idle_i | input | 1 | All banks precharged and idle |
| access_active_i | input | 1 | A read or write burst is in progress |
| init_done_i | input | 1 | Initialisation finished after deep power-down |
| pwr_state_o | output | 3 | Current state code (see requirements) |
| cmd_accept_o | output | 1 | Ordinary commands may be issued |
| illegal_o | output | 1 | Sticky illegal-sequence flag |

## Verification
The end of the recovery count and the arrival of the second NOP can land on the same edge. Each can also gate the release on its own. The bench provokes both orders: NOPs that arrive early, NOPs that arrive only after the count has expired, and the second NOP on exactly the last counting edge. Each case is judged by the cycle in which the state returns to NORMAL, compared against a bench model that counts edges and NOPs independently.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

    typedef enum logic [2:0] {
        CMD_INHIBIT = 3'd0,
        CMD_NOP     = 3'd1,
        CMD_AREF    = 3'd2,
        CMD_BST     = 3'd3,
        CMD_OTHER   = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        PS_NORMAL = 3'd0,
        PS_PDOWN  = 3'd1,
        PS_SREF   = 3'd2,
        PS_SREXIT = 3'd3,
        PS_SUSP   = 3'd4,
        PS_DEEP   = 3'd5,
        PS_UNINIT = 3'd6
    } pstate_e;

    typedef struct packed {
        logic quiet;
        logic nop;
        logic aref;
        logic bst;
    } cmd_class_t;

    typedef struct packed {
        pstate_e st;
        logic    cke;
        logic    ill;
    } trk_t;

endpackage

// File: rtl/sdram_pwr_cmd_class.sv
module sdram_pwr_cmd_class
    import sdram_pwr_pkg::*;
(
    input  logic [2:0] cmd_i,
    output cmd_class_t cls_o
);
    always_comb begin
        cls_o = '0;
        case (cmd_i)
            3'(CMD_INHIBIT): cls_o.quiet = 1'b1;
            3'(CMD_NOP): begin
                cls_o.quiet = 1'b1;
                cls_o.nop   = 1'b1;
            end
            3'(CMD_AREF):    cls_o.aref = 1'b1;
            3'(CMD_BST):     cls_o.bst  = 1'b1;
            default:         cls_o = '0;
        endcase
    end
endmodule

// File: rtl/sdram_pwr_entry_sel.sv
module sdram_pwr_entry_sel
    import sdram_pwr_pkg::*;
(
    input  cmd_class_t cls_i,
    input  logic       banks_idle_i,
    input  logic       access_active_i,
    output pstate_e    target_o,
    output logic       ok_o
);
    always_comb begin
        target_o = PS_NORMAL;
        ok_o     = 1'b0;
        if (access_active_i) begin
            target_o = PS_SUSP;
            ok_o     = 1'b1;
        end else if (banks_idle_i) begin
            if (cls_i.quiet) begin
                target_o = PS_PDOWN;
                ok_o     = 1'b1;
            end else if (cls_i.aref) begin
                target_o = PS_SREF;
                ok_o     = 1'b1;
            end else if (cls_i.bst) begin
                target_o = PS_DEEP;
                ok_o     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdram_pwr_xsr_timer.sv
module sdram_pwr_xsr_timer #(
    parameter int XSR_CYCLES = 6,
    parameter int MIN_NOPS   = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic run_i,
    input  logic nop_i,
    output logic done_o
);
    localparam int CW = $clog2(XSR_CYCLES + 1);
    localparam int NW = $clog2(MIN_NOPS + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(XSR_CYCLES);
    localparam logic [NW-1:0] NOP_MAX  = NW'(MIN_NOPS);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [NW-1:0] nop_d, nop_q;

    always_comb begin
        cnt_d = cnt_q;
        nop_d = nop_q;
        if (load_i) begin
            cnt_d = CNT_LOAD;
            nop_d = '0;
        end else if (run_i) begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            if (nop_i && nop_q < NOP_MAX) nop_d = nop_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            nop_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            nop_q <= nop_d;
        end
    end

    assign done_o = (cnt_q == '0) && (nop_q >= NOP_MAX);
endmodule

// File: rtl/sdram_pwr_tracker.sv
module sdram_pwr_tracker
    import sdram_pwr_pkg::*;
#(
    parameter int XSR_CYCLES = 6,
    parameter int MIN_NOPS   = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cke_i,
    input  logic [2:0] cmd_i,
    input  logic       banks_idle_i,
    input  logic       access_active_i,
    input  logic       init_done_i,
    output logic [2:0] pwr_state_o,
    output logic       cmd_accept_o,
    output logic       illegal_o
);
    cmd_class_t cls;
    pstate_e    ent_st;
    logic       ent_ok;
    logic       xsr_load;
    logic       xsr_done;
    logic       bad;
    trk_t       trk_d, trk_q;

    sdram_pwr_cmd_class u_cls (
        .cmd_i (cmd_i),
        .cls_o (cls)
    );

    sdram_pwr_entry_sel u_ent (
        .cls_i           (cls),
        .banks_idle_i    (banks_idle_i),
        .access_active_i (access_active_i),
        .target_o        (ent_st),
        .ok_o            (ent_ok)
    );

    sdram_pwr_xsr_timer #(
        .XSR_CYCLES (XSR_CYCLES),
        .MIN_NOPS   (MIN_NOPS)
    ) u_xsr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (xsr_load),
        .run_i  (trk_q.st == PS_SREXIT),
        .nop_i  (cls.nop),
        .done_o (xsr_done)
    );

    always_comb begin
        trk_d     = trk_q;
        trk_d.cke = cke_i;
        xsr_load  = 1'b0;
        bad       = 1'b0;
        case (trk_q.st)
            PS_NORMAL: begin
                if (!cke_i) begin
                    if (trk_q.cke && ent_ok) trk_d.st = ent_st;
                    else                     bad = 1'b1;
                end
            end
            PS_PDOWN: begin
                if (cke_i) begin
                    if (cls.quiet) trk_d.st = PS_NORMAL;
                    else           bad = 1'b1;
                end
            end
            PS_SREF: begin
                if (cke_i) begin
                    if (cls.quiet) begin
                        trk_d.st = PS_SREXIT;
                        xsr_load = 1'b1;
                    end else begin
                        bad = 1'b1;
                    end
                end
            end
            PS_SREXIT: begin
                if (!cke_i || !cls.quiet) bad = 1'b1;
                else if (xsr_done)        trk_d.st = PS_NORMAL;
            end
            PS_SUSP: begin
                if (cke_i) trk_d.st = PS_NORMAL;
            end
            PS_DEEP: begin
                if (cke_i) begin
                    if (cls.quiet) trk_d.st = PS_UNINIT;
                    else           bad = 1'b1;
                end
            end
            PS_UNINIT: begin
                if (!cls.quiet)               bad = 1'b1;
                else if (init_done_i && cke_i) trk_d.st = PS_NORMAL;
            end
            default: begin
                trk_d.st = PS_NORMAL;
                bad      = 1'b1;
            end
        endcase
        trk_d.ill = trk_q.ill | bad;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            trk_q.st  <= PS_NORMAL;
            trk_q.cke <= 1'b1;
            trk_q.ill <= 1'b0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign pwr_state_o  = trk_q.st;
    assign cmd_accept_o = (trk_q.st == PS_NORMAL);
    assign illegal_o    = trk_q.ill;
endmodule

// File: rtl/sdram_pwr_tracker_chk.sv
module sdram_pwr_tracker_chk
    import sdram_pwr_pkg::*;
#(
    parameter int XSR_CYCLES = 6
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cke_i,
    input logic [2:0] cmd_i,
    input logic       init_done_i,
    input logic [2:0] pwr_state_o,
    input logic       cmd_accept_o,
    input logic       illegal_o
);
    logic [15:0] sr_cyc;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                          sr_cyc <= '0;
        else if (pwr_state_o != 3'(PS_SREXIT)) sr_cyc <= '0;
        else if (sr_cyc != 16'hFFFF)          sr_cyc <= sr_cyc + 16'd1;
    end

    AST_ACCEPT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o != 3'(PS_NORMAL)) |-> !cmd_accept_o); // R9

    AST_ILLEGAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |=> illegal_o); // R10

    AST_PDOWN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o == 3'(PS_PDOWN) && !cke_i) |=> (pwr_state_o == 3'(PS_PDOWN))); // R2

    AST_SREF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o == 3'(PS_SREF) && !cke_i) |=> (pwr_state_o == 3'(PS_SREF))); // R3

    AST_SUSP_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o == 3'(PS_SUSP) && cke_i) |=> (pwr_state_o == 3'(PS_NORMAL) && cmd_accept_o)); // R5

    AST_RECOVERY_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o == 3'(PS_SREXIT) && sr_cyc < 16'(XSR_CYCLES)) |=> (pwr_state_o == 3'(PS_SREXIT))); // R6

    AST_DEEP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o == 3'(PS_DEEP) && cke_i && cmd_i <= 3'd1) |=> (pwr_state_o == 3'(PS_UNINIT))); // R8

    AST_UNINIT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o == 3'(PS_UNINIT) && !init_done_i) |=> (pwr_state_o == 3'(PS_UNINIT))); // R8
endmodule

bind sdram_pwr_tracker sdram_pwr_tracker_chk #(.XSR_CYCLES(XSR_CYCLES)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cke_i        (cke_i),
    .cmd_i        (cmd_i),
    .init_done_i  (init_done_i),
    .pwr_state_o  (pwr_state_o),
    .cmd_accept_o (cmd_accept_o),
    .illegal_o    (illegal_o)
);

// File: tb/sdram_pwr_tracker_tb.sv
module sdram_pwr_tracker_tb;
    localparam int XSR = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic [2:0] cmd = 3'd0;
    logic       idle = 1'b1;
    logic       act = 1'b0;
    logic       initd = 1'b0;
    logic [2:0] st;
    logic       acc;
    logic       ill;

    int checks = 0;
    int fails  = 0;

    int m_st, m_cnt, m_nop;
    bit m_cke, m_ill;

    always #4 clk = ~clk;

    sdram_pwr_tracker #(.XSR_CYCLES(XSR), .MIN_NOPS(2)) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .cke_i (cke), .cmd_i (cmd),
        .banks_idle_i (idle), .access_active_i (act), .init_done_i (initd),
        .pwr_state_o (st), .cmd_accept_o (acc), .illegal_o (ill)
    );

    function automatic string tag_of(int s);
        case (s)
            1: return "R2";
            2: return "R3";
            3: return "R6";
            4: return "R5";
            5: return "R4";
            6: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic model_edge(bit c, logic [2:0] k, bit id, bit ac, bit ini);
        bit quiet = (k == 3'd0) || (k == 3'd1);
        bit bad = 0;
        int nst = m_st;
        bool_done: begin end
        case (m_st)
            0: if (!c) begin
                   if (!m_cke) bad = 1;
                   else if (ac) nst = 4;
                   else if (id && quiet) nst = 1;
                   else if (id && k == 3'd2) nst = 2;
                   else if (id && k == 3'd3) nst = 5;
                   else bad = 1;
               end
            1: if (c) begin if (quiet) nst = 0; else bad = 1; end
            2: if (c) begin
                   if (quiet) begin nst = 3; m_cnt = XSR; m_nop = 0; end
                   else bad = 1;
               end
            3: begin
                   if (!c || !quiet) bad = 1;
                   else if (m_cnt == 0 && m_nop >= 2) nst = 0;
                   if (m_cnt > 0) m_cnt--;
                   if (k == 3'd1 && m_nop < 2) m_nop++;
               end
            4: if (c) nst = 0;
            5: if (c) begin if (quiet) nst = 6; else bad = 1; end
            6: if (!quiet) bad = 1; else if (ini && c) nst = 0;
            default: ;
        endcase
        m_st  = nst;
        m_cke = c;
        m_ill = m_ill | bad;
    endtask

    task automatic compare(string tag);
        bit exp_acc = (m_st == 0);
        checks++;
        if (st !== 3'(m_st) || acc !== exp_acc || ill !== m_ill) begin
            fails++;
            $display("FAIL %s: state=%0d/%0d accept=%0d/%0d illegal=%0d/%0d (actual/expected)",
                     tag, st, m_st, acc, exp_acc, ill, m_ill);
        end
    endtask

    task automatic step(string tag, bit c, logic [2:0] k, bit id, bit ac, bit ini);
        cke = c; cmd = k; idle = id; act = ac; initd = ini;
        model_edge(c, k, id, ac, ini);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cke = 1'b1; cmd = 3'd0; idle = 1'b1; act = 1'b0; initd = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_cke = 1; m_ill = 0; m_cnt = 0; m_nop = 0;
        compare("R1");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run=%0d/%0d (actual/expected)", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5D7A_11C3));
        @(negedge clk);
        do_reset();

        // R2 power-down entry, hold under any command, exit with inhibit
        step("R2", 0, 3'd1, 1, 0, 0);
        step("R2", 0, 3'd4, 1, 0, 0);
        step("R9", 0, 3'd2, 1, 0, 0);
        step("R2", 1, 3'd0, 1, 0, 0);

        // R4 burst terminate with CKE high is a normal command
        step("R4", 1, 3'd3, 1, 0, 0);

        // R3 self refresh; R6 early NOPs, release after count
        step("R3", 0, 3'd2, 1, 0, 0);
        step("R3", 0, 3'd4, 1, 0, 0);
        step("R6", 1, 3'd1, 1, 0, 0);
        step("R6", 1, 3'd1, 1, 0, 0);
        step("R6", 1, 3'd1, 1, 0, 0);
        for (int i = 0; i < XSR; i++) step("R6", 1, 3'd0, 1, 0, 0);

        // R6 second NOP on the last counting edge
        step("R3", 0, 3'd2, 1, 0, 0);
        step("R6", 1, 3'd0, 1, 0, 0);
        for (int i = 0; i < XSR - 2; i++) step("R6", 1, 3'd0, 1, 0, 0);
        step("R6", 1, 3'd1, 1, 0, 0);
        step("R6", 1, 3'd1, 1, 0, 0);
        step("R6", 1, 3'd0, 1, 0, 0);

        // R7 inhibit only: count expires, block waits for two NOPs
        step("R3", 0, 3'd2, 1, 0, 0);
        step("R7", 1, 3'd0, 1, 0, 0);
        for (int i = 0; i < XSR + 3; i++) step("R7", 1, 3'd0, 1, 0, 0);
        step("R7", 1, 3'd1, 1, 0, 0);
        step("R7", 1, 3'd1, 1, 0, 0);
        step("R7", 1, 3'd0, 1, 0, 0);

        // R4 / R8 deep power-down and wake through UNINIT
        step("R4", 0, 3'd3, 1, 0, 0);
        step("R4", 0, 3'd4, 1, 0, 0);
        step("R8", 1, 3'd1, 1, 0, 0);
        step("R8", 1, 3'd0, 1, 0, 0);
        step("R8", 0, 3'd1, 1, 0, 1);
        step("R8", 1, 3'd0, 1, 0, 1);

        // R5 clock suspend during an access
        step("R5", 0, 3'd4, 0, 1, 0);
        step("R5", 0, 3'd2, 0, 1, 0);
        step("R5", 1, 3'd4, 0, 1, 0);
        step("R5", 1, 3'd4, 0, 1, 0);

        // R10 illegal fall with other command, sticky, reset clears
        step("R10", 0, 3'd4, 1, 0, 0);
        step("R10", 1, 3'd1, 1, 0, 0);
        step("R10", 1, 3'd1, 1, 0, 0);
        do_reset();
        step("R10", 0, 3'd1, 0, 0, 0);
        do_reset();
        step("R10", 0, 3'd2, 1, 0, 0);
        step("R10", 1, 3'd1, 1, 0, 0);
        step("R10", 0, 3'd1, 1, 0, 0);
        do_reset();

        // constrained random segments
        for (int seg = 0; seg < 6; seg++) begin
            do_reset();
            for (int i = 0; i < 400; i++) begin
                int r  = int'($urandom_range(0, 99));
                int rc = int'($urandom_range(0, 99));
                bit c;
                logic [2:0] k;
                bit low_state = (m_st == 1 || m_st == 2 || m_st == 4 || m_st == 5);
                if (low_state) c = (r < 15);
                else           c = (r >= 10);
                if (rc < 45 - seg * 2)      k = 3'd1;
                else if (rc < 80)           k = 3'd0;
                else if (rc < 88)           k = 3'd2;
                else if (rc < 94)           k = 3'd3;
                else if (rc < 97 + seg / 2) k = 3'd4;
                else                        k = 3'($urandom_range(5, 7));
                step(tag_of(m_st), c, k, $urandom_range(0, 3) != 0,
                     $urandom_range(0, 4) == 0, $urandom_range(0, 9) == 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule